// File: doc/BRIEF.md
# SAR ADC Conversion Controller

This block is the digital sequencer and register front end of a 10-bit successive-approximation converter. Software programs one control/status register that holds the mode, the channel, the interrupt enable and a start bit. The block then drives the channel select and a trial code to an external DAC. It samples a one-bit comparator answer at the end of every approximation step and builds the result from the most significant bit down to the least significant bit.

A conversion begins on a register write that sets the start bit, or on the external trigger input while the block is idle. In single mode one channel is converted once. At the end the start bit clears itself, the done flag rises and the result lands in one of four result registers, chosen by the low two channel bits. In scan mode the block walks from the base of the selected channel's group of four up to the selected channel. It repeats this sequence until software stops it, and it raises the done flag after every complete pass. The done flag can only be cleared by a status read while it is set, followed by a write of zero to it. An interrupt request follows the done flag while interrupts are enabled.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset the control register reads 0, all four result registers read 0 and irq is low.
- R2: A conversion decides one bit per step, from the MSB down to the LSB. Each step lasts STEP_CYC clocks. The trial code is the bits kept so far plus the bit under test. cmp_in is sampled on the last clock of the step, and 1 (input at or above the trial code) keeps the bit. The result is available 10*STEP_CYC clocks after the starting edge.
- R3: A write to address 0 with bit 0 set starts a conversion. ext_trig high while idle starts one with the stored mode and channel. ext_trig while a conversion runs has no effect.
- R4: When a single-mode conversion ends, three things happen on the same edge: the result is stored, the done bit (bit 1) is set, and the start bit (bit 0) is cleared.
- R5: The done bit clears only on a write to address 0 with bit 1 at 0 that follows a read of address 0 made while done was set. Without that read, the write leaves done at 1.
- R6: irq is high exactly while done is 1 and the interrupt-enable bit (bit 2) is 1.
- R7: A write to address 0 with bit 0 at 0 during a conversion stops it at once. It updates no result register and leaves done unchanged.
- R8: Control fields are bit 3 (scan) and bits 6:4 (channel). Result registers A, B, C and D read at addresses 4, 5, 6 and 7. Channel c writes the register at address 4 + c[1:0], so channels 0 and 4 share register A.
- R9: In scan mode, channels from {c[2],00} up to the selected channel c are converted in order and the sequence repeats. Done is set when the last channel of each pass ends. The start bit stays 1 until software clears it.
- R10: A write with bit 0 set during a conversion restarts from the first step with the newly written mode and channel. The interrupted conversion stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (arms done clearing) |
| bus_addr | input | 3 | Register address: 0 control, 4..7 results |
| bus_wdata | input | 7 | Control write data |
| bus_rdata | output | 10 | Read data for the addressed register (combinational) |
| ext_trig | input | 1 | External conversion trigger |
| cmp_in | input | 1 | Comparator answer: input at or above dac_code |
| chan_sel | output | 3 | Analog channel being converted |
| dac_code | output | 10 | Trial code for the DAC |
| irq | output | 1 | Conversion interrupt request |

## Verification
A single conversion's start bit is due to read 0, and its done bit 1, exactly 10*STEP_CYC edges after the edge that took the start. The bench counts falling edges from that edge and compares the count with the expected figure. In scan mode the done bit is due after 3*10*STEP_CYC edges for a three-channel pass, so the bench looks one edge before and on that edge. Register and irq effects of a write or trigger are due on the next rising edge, so every observation is made at the following falling edge. The comparator is modelled combinationally from chan_sel and dac_code against a stored analog value. Each result is therefore expected to equal that stored value exactly.

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
  parameter int RES      = 10,
  parameter int STEP_CYC = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic           bus_rd,
  input  logic [2:0]     bus_addr,
  input  logic [6:0]     bus_wdata,
  output logic [RES-1:0] bus_rdata,
  input  logic           ext_trig,
  input  logic           cmp_in,
  output logic [2:0]     chan_sel,
  output logic [RES-1:0] dac_code,
  output logic           irq
);
  localparam int CW = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
  localparam logic [RES-1:0] MSB = {1'b1, {(RES-1){1'b0}}};

  logic go, done, ie, scan, armed;
  logic [2:0] ch, cur;
  logic [RES-1:0] sar, probe;
  logic [CW-1:0] cnt;
  logic [RES-1:0] res_q [4];

  wire ctl_wr   = bus_wr && bus_addr == 3'd0;
  wire ctl_rd   = bus_rd && bus_addr == 3'd0;
  wire hw_start = !go && ext_trig && !ctl_wr;
  wire step_end = go && cnt == CW'(STEP_CYC - 1);
  wire [RES-1:0] trial = sar | probe;
  wire [RES-1:0] kept  = cmp_in ? trial : sar;
  wire conv_end = step_end && probe[0] && !ctl_wr;
  wire pass_end = conv_end && (!scan || cur == ch);
  wire [2:0] base = {ch[2], 2'b00};

  wire       nscan = ctl_wr ? bus_wdata[3]   : scan;
  wire [2:0] nch   = ctl_wr ? bus_wdata[6:4] : ch;

  assign chan_sel = cur;
  assign dac_code = trial;
  assign irq      = done && ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go <= 1'b0; ie <= 1'b0; scan <= 1'b0; ch <= '0; cur <= '0;
      sar <= '0; probe <= MSB; cnt <= '0;
      for (int i = 0; i < 4; i++) res_q[i] <= '0;
    end else begin
      if (ctl_wr) begin
        ie   <= bus_wdata[2];
        scan <= bus_wdata[3];
        ch   <= bus_wdata[6:4];
      end
      if (ctl_wr || hw_start) begin
        go    <= ctl_wr ? bus_wdata[0] : 1'b1;
        cur   <= nscan ? {nch[2], 2'b00} : nch;
        sar   <= '0;
        probe <= MSB;
        cnt   <= '0;
      end else if (go) begin
        if (step_end) begin
          cnt <= '0;
          if (probe[0]) begin
            res_q[cur[1:0]] <= kept;
            sar   <= '0;
            probe <= MSB;
            if (!scan) go <= 1'b0;
            else cur <= (cur == ch) ? base : cur + 3'd1;
          end else begin
            sar   <= kept;
            probe <= probe >> 1;
          end
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done  <= 1'b0;
      armed <= 1'b0;
    end else begin
      if (pass_end) done <= 1'b1;
      else if (ctl_wr && !bus_wdata[1] && armed) done <= 1'b0;
      if (ctl_wr) armed <= 1'b0;
      else if (ctl_rd && done) armed <= 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == 3'd0) bus_rdata[6:0] = {ch, scan, ie, done, go};
    else if (bus_addr[2]) bus_rdata = res_q[bus_addr[1:0]];
  end
endmodule

// File: rtl/sar_adc_chk.sv
module sar_adc_chk #(
  parameter int RES = 10
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ctl_wr,
  input logic           wr_go,
  input logic           wr_done,
  input logic           go,
  input logic           done,
  input logic           scan,
  input logic [2:0]     ch,
  input logic [2:0]     chan_sel,
  input logic [RES-1:0] dac_code,
  input logic           step_end
);
  a_r2_code_held_in_step: assert property (@(posedge clk) disable iff (!rst_n)
    (go && $past(go) && !$past(step_end) && !$past(ctl_wr)) |-> $stable(dac_code));

  a_r4_single_go_drops_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && !scan) |-> !go);

  a_r5_done_needs_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> $past(ctl_wr && !wr_done));

  a_r7_abort_stops: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctl_wr && !wr_go) |-> !go);

  a_r9_scan_in_group: assert property (@(posedge clk) disable iff (!rst_n)
    (go && scan) |-> (chan_sel[2] == ch[2] && chan_sel <= ch));
endmodule

bind sar_adc_ctrl sar_adc_chk #(.RES(RES)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .wr_go(bus_wdata[0]),
  .wr_done(bus_wdata[1]), .go(go), .done(done), .scan(scan), .ch(ch),
  .chan_sel(chan_sel), .dac_code(dac_code), .step_end(step_end)
);

// File: tb/sar_adc_ctrl_test.sv
`timescale 1ns/1ps
module sar_adc_ctrl_test;
  localparam int STEP = 4;
  localparam int CONV = 10 * STEP;

  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0, ext_trig = 0;
  logic [2:0] bus_addr = 0;
  logic [6:0] bus_wdata = 0;
  logic [9:0] bus_rdata, dac_code;
  logic [2:0] chan_sel;
  logic irq, cmp_in;
  logic [9:0] ain [8];
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sar_adc_ctrl #(.RES(10), .STEP_CYC(STEP)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_trig(ext_trig), .cmp_in(cmp_in), .chan_sel(chan_sel),
    .dac_code(dac_code), .irq(irq));

  assign cmp_in = ain[chan_sel] >= dac_code;

  function automatic [9:0] ctl_word(input [2:0] c, input s, input e, input d, input g);
    return {3'b000, c, s, e, d, g};
  endfunction
  function automatic [2:0] slot(input [2:0] c);
    return {1'b1, c[1:0]};
  endfunction

  task automatic check(input string req, input [15:0] act, input [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input [6:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = 0; bus_wdata = d;
    @(negedge clk); bus_wr = 0; bus_addr = 0;
  endtask
  task automatic rd(input [2:0] a, output [9:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0; bus_addr = 0;
  endtask
  task automatic wait_idle(output int n);
    n = 0;
    while (bus_rdata[0] && n < 2000) begin @(negedge clk); n++; end
  endtask
  task automatic idle(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  task automatic conv_single(input [2:0] c, input e);
    int n; logic [9:0] v;
    wr({c, 1'b0, e, 1'b0, 1'b1});
    wait_idle(n);
    check("R2 conversion length", n, CONV);
    rd(slot(c), v);
    check("R8 R2 result value", v, ain[c]);
    rd(3'd0, v);
    check("R4 status after end", v, ctl_word(c, 0, e, 1, 0));
    check("R6 irq follows done and enable", irq, e);
    wr({c, 1'b0, e, 1'b0, 1'b0});
    check("R5 done cleared after read", bus_rdata[1], 0);
    check("R6 irq low once cleared", irq, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [9:0] v, oldc;
    int n;
    void'($urandom(32'd2024));
    for (int i = 0; i < 8; i++) ain[i] = 10'($urandom);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    rd(3'd0, v); check("R1 control reset", v, 0);
    for (int i = 4; i < 8; i++) begin rd(3'(i), v); check("R1 result reset", v, 0); end
    check("R1 irq reset", irq, 0);

    ain[1] = 10'h2A5;
    conv_single(3'd1, 1'b1);
    ain[2] = 10'h000; conv_single(3'd2, 1'b0);
    ain[3] = 10'h3FF; conv_single(3'd3, 1'b1);
    ain[7] = 10'h200; conv_single(3'd7, 1'b1);
    ain[6] = 10'h1FF; conv_single(3'd6, 1'b0);

    for (int k = 0; k < 10; k++) begin
      logic [2:0] c = 3'($urandom);
      ain[c] = 10'($urandom);
      conv_single(c, 1'($urandom));
    end

    // R8: channels 0 and 4 share register A
    ain[0] = 10'h111; ain[4] = 10'h2EE;
    conv_single(3'd0, 1'b0);
    conv_single(3'd4, 1'b0);
    rd(3'd4, v); check("R8 channel 4 overwrites A", v, 10'h2EE);

    // R5: zero write without a prior read keeps done
    wr({3'd1, 1'b0, 1'b1, 1'b0, 1'b1});
    wait_idle(n);
    wr({3'd1, 1'b0, 1'b1, 1'b0, 1'b0});
    check("R5 done kept without read", bus_rdata[1], 1);
    check("R6 irq kept", irq, 1);
    rd(3'd0, v);
    wr({3'd1, 1'b0, 1'b1, 1'b1, 1'b0});
    check("R5 write of one keeps done", bus_rdata[1], 1);
    rd(3'd0, v);
    wr({3'd1, 1'b0, 1'b1, 1'b0, 1'b0});
    check("R5 read then zero clears", bus_rdata[1], 0);

    // R7: abort
    rd(3'd6, oldc);
    ain[2] = ~oldc;
    wr({3'd2, 1'b0, 1'b1, 1'b0, 1'b1});
    idle(15);
    wr({3'd2, 1'b0, 1'b1, 1'b0, 1'b0});
    check("R7 abort clears start", bus_rdata[0], 0);
    idle(CONV + 5);
    rd(3'd6, v); check("R7 no result on abort", v, oldc);
    rd(3'd0, v); check("R7 done untouched by abort", v, ctl_word(3'd2, 0, 1, 0, 0));
    check("R7 irq stays low", irq, 0);

    // R10: restart with a new channel
    ain[3] = 10'h0C3;
    wr({3'd2, 1'b0, 1'b0, 1'b0, 1'b1});
    idle(10);
    wr({3'd3, 1'b0, 1'b0, 1'b0, 1'b1});
    wait_idle(n);
    check("R10 restart length", n, CONV);
    rd(3'd7, v); check("R10 new channel result", v, 10'h0C3);
    rd(3'd6, v); check("R10 interrupted channel untouched", v, oldc);
    rd(3'd0, v); wr({3'd3, 4'b0000});

    // R3: external trigger, held while busy
    wr({3'd5, 1'b0, 1'b1, 1'b0, 1'b0});
    ain[5] = 10'h155;
    check("R3 idle before trigger", bus_rdata[0], 0);
    @(negedge clk); ext_trig = 1;
    @(negedge clk);
    check("R3 trigger starts", bus_rdata[0], 1);
    idle(10);
    ext_trig = 0;
    wait_idle(n);
    check("R3 trigger while busy ignored", n, CONV - 10);
    rd(3'd5, v); check("R3 triggered result", v, 10'h155);
    check("R6 irq on triggered end", irq, 1);
    rd(3'd0, v); wr({3'd5, 4'b0000});

    // R9: scan 4..6
    ain[4] = 10'h0AA; ain[5] = 10'h355; ain[6] = 10'h3C0;
    wr({3'd6, 1'b1, 1'b1, 1'b0, 1'b1});
    idle(3 * CONV - 1);
    check("R9 done not yet before pass end", bus_rdata[1], 0);
    idle(1);
    check("R9 done at pass end", bus_rdata[1], 1);
    check("R9 start stays set", bus_rdata[0], 1);
    check("R6 irq in scan", irq, 1);
    rd(3'd4, v); check("R9 scan A", v, 10'h0AA);
    rd(3'd5, v); check("R9 scan B", v, 10'h355);
    rd(3'd6, v); check("R9 scan C", v, 10'h3C0);
    ain[4] = 10'h001; ain[5] = 10'h2D2; ain[6] = 10'h0F0;
    idle(3 * CONV + 5);
    rd(3'd4, v); check("R9 second pass A", v, 10'h001);
    rd(3'd5, v); check("R9 second pass B", v, 10'h2D2);
    rd(3'd6, v); check("R9 second pass C", v, 10'h0F0);
    rd(3'd7, v); check("R9 D outside group untouched", v, 10'h0C3);
    wr({3'd6, 1'b1, 1'b1, 1'b0, 1'b0});
    check("R9 software stop", bus_rdata[0], 0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule